// File: doc/BRIEF.md
# Noise-Averaged Successive Approximation Controller

This controller closes a digital test loop around a 16-bit DAC. It searches for the DAC code at which a noisy one-bit comparison changes state. The search is a binary one. The trial code begins at half scale, and each bit from the most significant to the least significant is then kept or dropped. Where a plain successive approximation register would take one comparator sample per bit, this block watches the comparator for a window of 2^M clock cycles and counts the cycles in which it is high. A majority vote over that window decides the bit, so noise near the switching point is averaged out instead of being frozen into the result.

The trial code stays constant for every whole window, so the device under test always sees a DC level. M trades test time against noise rejection. It is captured when a conversion starts. The controller is sequenced by four named states:
- `ST_IDLE` holds the last result.
- `ST_AVG` counts comparator highs for one trial bit.
- `ST_UPD` applies the vote and loads the next trial.
- `ST_FIN` flags completion for one cycle.

The transitions are:
- IDLE to AVG when start is seen.
- AVG to UPD on the last cycle of the window.
- UPD to AVG while bits remain.
- UPD to FIN after the lowest bit.
- FIN to IDLE unconditionally.

Top module: `avg_sar_ctrl`

## Requirements
- R1: When start is high in the idle state, the M input is captured at that clock edge. A value of 0 is treated as 1, and a value above 16 is treated as 16. From the next cycle on, `dac_code` is 0x8000 and `busy` is high.
- R2: Each trial bit is judged over exactly 2^M consecutive comparator samples, taken in the cycles that follow the trial code's appearance. One update cycle follows each window. `dac_code` does not change anywhere inside a window or during its update cycle.
- R3: A bit is kept (bit value 1) only when the number of high samples in its window is strictly greater than 2^(M-1). A count equal to 2^(M-1) clears the bit.
- R4: In the update cycle, the bit under test takes its vote result and the next lower bit is set to 1. The bits are handled from bit 15 down to bit 0, one window each, 16 windows per conversion. The new trial code is visible in the cycle after the update cycle.
- R5: `done` is high for exactly one cycle, in the cycle after the update of bit 0, with the final code on `dac_code`. After that cycle `busy` is low and the final code holds until the next accepted start.
- R6: A start pulse during a conversion has no effect. Changing the M input during a conversion has no effect on window length or on the result.
- R7: The comparator input is ignored during update cycles and while idle.
- R8: A synchronous reset drives `dac_code` to 0, and `busy` and `done` low, in the cycle after it is sampled, and aborts any conversion.
- R9: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| m_sel | input | 5 | Log2 of the averaging window length, clamped to 1..16 |
| cmp_in | input | 1 | Comparator decision: high means the unknown is above the trial level |
| dac_code | output | 16 | Trial code during a conversion, final code afterwards |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start` and `cmp_in` are synchronous to `clk` and already settled, and that reset lasts at least one edge. They do not assume that `start` is held low while busy, because ignoring such pulses is itself a checked property. The stimulus drives every input on the falling edge. It injects random start pulses and random M values in the middle of conversions. The comparator is driven either as noisy random samples biased by a hidden target level or as exact tie and tie-plus-one patterns, so each vote outcome is known to the bench before the design reports it.

// File: rtl/avg_sar_pkg.sv
package avg_sar_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_AVG  = 2'd1,
        ST_UPD  = 2'd2,
        ST_FIN  = 2'd3
    } sar_state_e;

endpackage

// File: rtl/avg_sar_window.sv
// Reference counter: marks the last cycle of a 2^M sample window.
module avg_sar_window #(
    parameter int CNT_W = 16,
    parameter int M_W   = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           en,
    input  logic [M_W-1:0] m_eff,
    output logic           last
);

    logic [CNT_W-1:0] ref_q;
    logic [CNT_W:0]   lim_ext;
    logic [CNT_W-1:0] limit;

    always_comb begin
        lim_ext = ({{CNT_W{1'b0}}, 1'b1} << m_eff) - {{CNT_W{1'b0}}, 1'b1};
        limit   = lim_ext[CNT_W-1:0];
    end

    assign last = en && (ref_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ref_q <= '0;
        end else if (en) begin
            ref_q <= last ? '0 : ref_q + 1'b1;
        end
    end

endmodule

// File: rtl/avg_sar_vote.sv
// Data counter and majority decision flip-flop.
module avg_sar_vote #(
    parameter int CNT_W = 16,
    parameter int M_W   = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           en,
    input  logic           last,
    input  logic           cmp,
    input  logic [M_W-1:0] m_eff,
    output logic           decision
);

    logic [CNT_W:0] hi_q;
    logic [CNT_W:0] total;
    logic [CNT_W:0] half;
    logic [M_W-1:0] m_less;

    always_comb begin
        m_less = m_eff - {{(M_W-1){1'b0}}, 1'b1};
        half   = {{CNT_W{1'b0}}, 1'b1} << m_less;
        total  = hi_q + {{CNT_W{1'b0}}, cmp};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hi_q <= '0;
        end else if (en && cmp) begin
            hi_q <= hi_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            decision <= 1'b0;
        end else if (en && last) begin
            decision <= (total > half);
        end
    end

endmodule

// File: rtl/avg_sar_reg.sv
// Successive approximation register, one slice per bit.
module avg_sar_reg #(
    parameter int W     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_msb,
    input  logic             update,
    input  logic             keep,
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     code
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                code[b] <= 1'b0;
            end else if (load_msb) begin
                code[b] <= (b == W - 1);
            end else if (update) begin
                if (int'(idx) == b) begin
                    code[b] <= keep;
                end else if (int'(idx) == b + 1) begin
                    code[b] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/avg_sar_ctrl.sv
module avg_sar_ctrl
    import avg_sar_pkg::*;
#(
    parameter int DAC_W = 16,
    parameter int M_MAX = 16,
    parameter int MSEL_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MSEL_W-1:0] m_sel,
    input  logic              cmp_in,
    output logic [DAC_W-1:0]  dac_code,
    output logic              busy,
    output logic              done
);

    localparam int IDX_W = $clog2(DAC_W);
    localparam int M_W   = $clog2(M_MAX + 1);

    sar_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [M_W-1:0]   m_q;
    logic [M_W-1:0]   m_clamp;

    logic load_msb, cnt_clr, cnt_en, sar_upd, win_last, vote;

    // Clamp of the requested window exponent.
    always_comb begin
        if (m_sel == '0) begin
            m_clamp = M_W'(1);
        end else if (int'(m_sel) > M_MAX) begin
            m_clamp = M_W'(M_MAX);
        end else begin
            m_clamp = M_W'(m_sel);
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)        state_d = ST_AVG;
            ST_AVG:  if (win_last)     state_d = ST_UPD;
            ST_UPD:  state_d = (idx_q == '0) ? ST_FIN : ST_AVG;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and sequencing registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            m_q     <= M_W'(1);
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                idx_q <= IDX_W'(DAC_W - 1);
                m_q   <= m_clamp;
            end else if (state_q == ST_UPD && idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    // Outputs and control strobes.
    always_comb begin
        load_msb = 1'b0;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        sar_upd  = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                load_msb = start;
                cnt_clr  = start;
            end
            ST_AVG: cnt_en = 1'b1;
            ST_UPD: begin
                sar_upd = 1'b1;
                cnt_clr = 1'b1;
            end
            ST_FIN: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    avg_sar_window #(.CNT_W(M_MAX), .M_W(M_W)) win_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .m_eff (m_q),
        .last  (win_last)
    );

    avg_sar_vote #(.CNT_W(M_MAX), .M_W(M_W)) vote_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .en       (cnt_en),
        .last     (win_last),
        .cmp      (cmp_in),
        .m_eff    (m_q),
        .decision (vote)
    );

    avg_sar_reg #(.W(DAC_W), .IDX_W(IDX_W)) sar_i (
        .clk      (clk),
        .rst      (rst),
        .load_msb (load_msb),
        .update   (sar_upd),
        .keep     (vote),
        .idx      (idx_q),
        .code     (dac_code)
    );

endmodule

// File: rtl/avg_sar_chk.sv
module avg_sar_chk
    import avg_sar_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] dac_code,
    input logic [1:0]   st
);

    // R1: accepted start loads half scale and raises busy
    p_start_msb_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && dac_code == (W'(1) << (W - 1))));

    // R2: code holds while the window is being counted
    p_code_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_AVG && $past(st) == ST_AVG) |-> $stable(dac_code));

    // R5: done lasts one cycle and busy drops after it
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R5: final code held while idle without start
    p_final_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(dac_code));

    // R6: start during counting leaves the conversion running
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (rst)
        (start && st == ST_AVG) |=> busy);

    // R9: done only while busy
    p_done_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R8: reset clears the outputs
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && !busy && !done));

endmodule

bind avg_sar_ctrl avg_sar_chk #(.W(DAC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .dac_code (dac_code),
    .st       (state_q)
);

// File: tb/avg_sar_ctrl_tb.sv
module avg_sar_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  m_sel;
    logic        cmp_in;
    logic [15:0] dac_code;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned seed_init;

    always #10 clk = ~clk;

    avg_sar_ctrl dut_i (
        .clk(clk), .rst(rst), .start(start), .m_sel(m_sel),
        .cmp_in(cmp_in), .dac_code(dac_code), .busy(busy), .done(done)
    );

    function automatic int clamp_m(input int m);
        if (m < 1)  return 1;
        if (m > 16) return 16;
        return m;
    endfunction

    function automatic logic [15:0] next_trial(input logic [15:0] c, input int b, input logic keep);
        logic [15:0] r = c;
        r[b] = keep;
        if (b > 0) r[b-1] = 1'b1;
        return r;
    endfunction

    // mode 0: noisy biased by target, 1: exact tie, 2: one above tie
    function automatic logic gen_cmp(input int mode, input int k, input int half,
                                     input logic [15:0] code, input logic [15:0] tgt);
        if (mode == 1) return (k < half);
        if (mode == 2) return (k <= half);
        if (code < tgt) return ($urandom_range(99) < 85);
        return ($urandom_range(99) < 15);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(dac_code == 16'h0, "R8 code", int'(dac_code), 0);
        check(!busy && !done, "R8 flags", int'({busy, done}), 0);
    endtask

    task automatic run_conv(input int mset, input int mode, input logic [15:0] tgt, input int nbits);
        int meff = clamp_m(mset);
        int win = 1 << meff;
        int half = win / 2;
        logic [15:0] exp_c = 16'h8000;
        @(negedge clk);
        start = 1'b1; m_sel = 5'(mset); cmp_in = $urandom_range(1);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(dac_code == 16'h8000, "R1 first trial", int'(dac_code), 32'h8000);
        check(busy, "R9 busy after start", int'(busy), 1);
        for (int b = 15; b > 15 - nbits; b--) begin
            int hi = 0;
            for (int k = 0; k < win; k++) begin
                cmp_in = gen_cmp(mode, k, half, exp_c, tgt);
                hi += int'(cmp_in);
                start = ($urandom_range(7) == 0);   // R6 stray starts
                m_sel = 5'($urandom_range(31));     // R6 M changes
                @(posedge clk);
                @(negedge clk);
                check(dac_code == exp_c, "R2 code steady in window", int'(dac_code), int'(exp_c));
            end
            // update cycle: comparator must be ignored (R7)
            cmp_in = $urandom_range(1);
            start = $urandom_range(1);
            @(posedge clk);
            @(negedge clk);
            exp_c = next_trial(exp_c, b, hi > half);
            check(dac_code == exp_c, "R3 R4 vote and next trial", int'(dac_code), int'(exp_c));
            check(busy, "R9 busy during conversion", int'(busy), 1);
            if (b == 0) begin
                check(done, "R5 done pulse", int'(done), 1);
                start = 1'b0; cmp_in = $urandom_range(1);
                @(posedge clk);
                @(negedge clk);
                check(!done && !busy, "R5 done one cycle", int'({done, busy}), 0);
                for (int i = 0; i < 4; i++) begin
                    cmp_in = $urandom_range(1);
                    @(posedge clk);
                    @(negedge clk);
                    check(dac_code == exp_c, "R5 R7 final code held", int'(dac_code), int'(exp_c));
                end
            end else begin
                check(!done, "R5 no early done", int'(done), 0);
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        seed_init = $urandom(32'h5eed1);
        rst = 1'b1; start = 1'b0; m_sel = 5'd1; cmp_in = 1'b0;
        repeat (2) @(posedge clk);
        do_reset();
        // directed: tie clears every bit (R3), tie+1 keeps every bit
        run_conv(2, 1, 16'h0, 16);
        check(dac_code == 16'h0000, "R3 all ties", int'(dac_code), 0);
        run_conv(2, 2, 16'h0, 16);
        check(dac_code == 16'hFFFF, "R3 all above tie", int'(dac_code), 32'hFFFF);
        // M=0 clamps to 1 (R1)
        run_conv(0, 1, 16'h0, 16);
        check(dac_code == 16'h0000, "R1 clamp low", int'(dac_code), 0);
        // noisy random targets
        for (int t = 0; t < 8; t++) begin
            run_conv($urandom_range(1, 4), 0, 16'($urandom), 16);
        end
        run_conv(3, 0, 16'h0000, 16);
        run_conv(3, 0, 16'hFFFF, 16);
        // reset mid conversion (R8)
        run_conv(3, 0, 16'h1234, 5);
        do_reset();
        // M above range clamps to 16: first window 65536 samples (R1, R2)
        run_conv(31, 2, 16'h0, 1);
        check(dac_code == 16'hC000, "R1 clamp high", int'(dac_code), 32'hC000);
        do_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule